// File: doc/BRIEF.md
# Dual-Section Phase Comparator with Lock Qualification

This block compares a reference pulse train against a feedback pulse train for each of two loop sections, with every input sampled on the oscillator clock. For each section it measures the phase error as a count of oscillator cycles from one rising edge to the other. While one edge is leading it drives a pump request whose sign is set by a per-section polarity control. When the lagging edge arrives it closes the comparison with a one-cycle pulse on both pump lines. The drive is given as separate up, down and enable lines, and enable low stands for the high-impedance state.

Each comparison also feeds a lock qualifier that has hysteresis. A wide error clears lock at once. Lock is granted only after a run of consecutive narrow comparisons. A section held in power-save has its drive released and counts as locked. When it leaves power-save, its first comparison drive is capped in length so the loop is not pulled far off frequency. A single monitor output shows either the combined lock or one of the four raw pulse inputs.

Top module: `pfd_lock_top`

## Requirements
- R1: While a comparison is open and no closing pulse is present, exactly one pump line is active. With polarity high, a leading reference drives `pumpUp` and a leading feedback drives `pumpDn`. With polarity low the two lines are swapped.
- R2: `pumpEn` is high exactly when `pumpUp` or `pumpDn` is high. With no open comparison and no closing pulse, all three are low.
- R3: The clock edge that closes a comparison raises both `pumpUp` and `pumpDn` for exactly one cycle. This includes a zero-cycle error, where both rising edges are seen on the same clock edge.
- R4: The phase error is the number of clock edges from the first rising edge to the second. A repeated edge of the leading input does not restart the count, and the count saturates at `MAX_ERR`.
- R5: A comparison with error of `UNLOCK_CYC` or more clears the section's lock and its run of narrow comparisons.
- R6: A section becomes locked after `LOCK_RUN` consecutive comparisons with error of `LOCK_CYC` or less. An error between the two thresholds resets the run and leaves the lock state unchanged.
- R7: While `pwrSave` of a section is high, its drive lines are low from the next clock edge and the section counts as locked. Its own lock is cleared, so after release it must qualify again.
- R8: With `monSel` low, `lockMon` is high only when each section is locked or in power-save.
- R9: With `monSel` high, `lockMon` shows a raw input. `monSrc[0]` picks the section (0 or 1), and `monSrc[1]` picks the reference (0) or the feedback (1) input: 00 gives `refIn[0]`, 01 gives `refIn[1]`, 10 gives `fbIn[0]`, 11 gives `fbIn[1]`.
- R10: For the first comparison after power-save is released, the leading drive lasts at most `WAKE_CAP` cycles. The closing pulse is still issued, and later comparisons are not capped.
- R11: After synchronous reset all pump lines are low, no section is locked, and `lockMon` with `monSel` low equals the AND of the `pwrSave` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Synchronous reset, active low |
| refIn | input | 2 | Reference pulse train per section |
| fbIn | input | 2 | Feedback pulse train per section |
| polHigh | input | 2 | Per-section drive polarity |
| pwrSave | input | 2 | Per-section power-save, active high |
| monSel | input | 1 | 0: monitor shows combined lock, 1: raw input |
| monSrc | input | 2 | Raw input select (bit 0 section, bit 1 feedback) |
| pumpUp | output | 2 | Drive-high request per section |
| pumpDn | output | 2 | Drive-low request per section |
| pumpEn | output | 2 | Drive enable per section (low is high-impedance) |
| lockMon | output | 1 | Combined lock or monitored input |

## Verification
On every cycle, the bound properties check the following. A section kept in power-save stays released. The closing pulse on both pump lines never lasts longer than one cycle. A wide comparison always drops lock. Lock only rises right after a narrow comparison. With both sections in power-save, the combined lock reads high. The run length needed for lock, the reset of the run by a mid-width error, the wake-up cap and the monitor encoding all depend on a sequence of comparisons. Only the bench's scenarios and its per-cycle reference model can show those.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_REF = 2'd1, PH_FB = 2'd2} phase_e;

  typedef struct packed {
    logic clear;    // power-save: wipe count, run and lock
    logic start;    // a new comparison opens, count loads 1
    logic count;    // comparison still open, count advances
    logic finish;   // comparison closes this edge
    logic zeroErr;  // closing with both edges on one clock
  } cmp_strobe_t;
endpackage

// File: rtl/pfd_phase_ctrl.sv
module pfd_phase_ctrl
  import pfd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refIn,
  input  logic        fbIn,
  input  logic        polHigh,
  input  logic        pwrSave,
  input  logic        overCap,
  output cmp_strobe_t stb,
  output logic        pumpUp,
  output logic        pumpDn
);
  phase_e st, stNext;
  logic refQ, fbQ, dzQ, wakeFirst;
  logic refRise, fbRise, gate, driveHigh, lead;

  assign refRise = refIn & ~refQ;
  assign fbRise  = fbIn & ~fbQ;

  always_comb begin
    stb    = '0;
    stNext = st;
    if (pwrSave) begin
      stb.clear = 1'b1;
      stNext    = PH_IDLE;
    end else begin
      unique case (st)
        PH_REF: begin
          if (fbRise) begin
            stb.finish = 1'b1;
            stb.start  = refRise;
            stNext     = refRise ? PH_REF : PH_IDLE;
          end else begin
            stb.count = 1'b1;
          end
        end
        PH_FB: begin
          if (refRise) begin
            stb.finish = 1'b1;
            stb.start  = fbRise;
            stNext     = fbRise ? PH_FB : PH_IDLE;
          end else begin
            stb.count = 1'b1;
          end
        end
        default: begin
          if (refRise && fbRise) begin
            stb.finish  = 1'b1;
            stb.zeroErr = 1'b1;
          end else if (refRise) begin
            stb.start = 1'b1;
            stNext    = PH_REF;
          end else if (fbRise) begin
            stb.start = 1'b1;
            stNext    = PH_FB;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= PH_IDLE;
      refQ      <= 1'b0;
      fbQ       <= 1'b0;
      dzQ       <= 1'b0;
      wakeFirst <= 1'b0;
    end else begin
      st   <= stNext;
      refQ <= refIn;
      fbQ  <= fbIn;
      dzQ  <= stb.finish;
      if (pwrSave)         wakeFirst <= 1'b1;
      else if (stb.finish) wakeFirst <= 1'b0;
    end
  end

  assign lead      = (st == PH_REF) || (st == PH_FB);
  assign gate      = lead && !(wakeFirst && overCap);
  assign driveHigh = (st == PH_REF) ~^ polHigh;
  assign pumpUp    = dzQ | (gate & driveHigh);
  assign pumpDn    = dzQ | (gate & ~driveHigh);
endmodule

// File: rtl/pfd_err_dpath.sv
module pfd_err_dpath
  import pfd_pkg::*;
#(
  parameter int MAX_ERR    = 63,
  parameter int UNLOCK_CYC = 4,
  parameter int LOCK_CYC   = 2,
  parameter int LOCK_RUN   = 3,
  parameter int WAKE_CAP   = 3,
  localparam int CNT_W     = $clog2(MAX_ERR + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  cmp_strobe_t       stb,
  output logic              overCap,
  output logic [CNT_W-1:0]  errWidth,
  output logic              lockQ
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ERR);
  localparam logic [CNT_W-1:0] UNL_TH  = CNT_W'(UNLOCK_CYC);
  localparam logic [CNT_W-1:0] LCK_TH  = CNT_W'(LOCK_CYC);
  localparam logic [CNT_W-1:0] CAP_TH  = CNT_W'(WAKE_CAP);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LOCK_RUN);

  logic [CNT_W-1:0] cnt;
  logic [RUN_W-1:0] run;

  assign errWidth = stb.zeroErr ? '0 : cnt;
  assign overCap  = cnt > CAP_TH;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      cnt   <= '0;
      run   <= '0;
      lockQ <= 1'b0;
    end else begin
      if (stb.start)       cnt <= CNT_W'(1);
      else if (stb.count)  cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      else if (stb.finish) cnt <= '0;

      if (stb.finish) begin
        if (errWidth >= UNL_TH) begin
          lockQ <= 1'b0;
          run   <= '0;
        end else if (errWidth <= LCK_TH) begin
          run <= (run == RUN_MAX) ? run : run + 1'b1;
          if (run >= RUN_MAX - 1'b1) lockQ <= 1'b1;
        end else begin
          run <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
  import pfd_pkg::*;
#(
  parameter int MAX_ERR    = 63,
  parameter int UNLOCK_CYC = 4,
  parameter int LOCK_CYC   = 2,
  parameter int LOCK_RUN   = 3,
  parameter int WAKE_CAP   = 3
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] refIn,
  input  logic [1:0] fbIn,
  input  logic [1:0] polHigh,
  input  logic [1:0] pwrSave,
  input  logic       monSel,
  input  logic [1:0] monSrc,
  output logic [1:0] pumpUp,
  output logic [1:0] pumpDn,
  output logic [1:0] pumpEn,
  output logic       lockMon
);
  localparam int NSEC  = 2;
  localparam int CNT_W = $clog2(MAX_ERR + 1);

  logic [NSEC-1:0]            secLock;
  logic [NSEC-1:0]            finStb;
  logic [NSEC-1:0][CNT_W-1:0] errWidth;
  logic                       lockAll;
  logic                       rawPick;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    cmp_strobe_t stb;
    logic        overCap;

    pfd_phase_ctrl u_ctrl (
      .clk(clk), .rstN(rstN), .refIn(refIn[s]), .fbIn(fbIn[s]),
      .polHigh(polHigh[s]), .pwrSave(pwrSave[s]), .overCap(overCap),
      .stb(stb), .pumpUp(pumpUp[s]), .pumpDn(pumpDn[s])
    );

    pfd_err_dpath #(
      .MAX_ERR(MAX_ERR), .UNLOCK_CYC(UNLOCK_CYC), .LOCK_CYC(LOCK_CYC),
      .LOCK_RUN(LOCK_RUN), .WAKE_CAP(WAKE_CAP)
    ) u_dp (
      .clk(clk), .rstN(rstN), .stb(stb), .overCap(overCap),
      .errWidth(errWidth[s]), .lockQ(secLock[s])
    );

    assign finStb[s] = stb.finish;
    assign pumpEn[s] = pumpUp[s] | pumpDn[s];
  end

  assign lockAll = &(pwrSave | secLock);
  assign rawPick = monSrc[1] ? fbIn[monSrc[0]] : refIn[monSrc[0]];
  assign lockMon = monSel ? rawPick : lockAll;
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk #(
  parameter int MAX_ERR    = 63,
  parameter int UNLOCK_CYC = 4,
  parameter int LOCK_CYC   = 2,
  localparam int CNT_W     = $clog2(MAX_ERR + 1)
)(
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            pwrSave,
  input logic                  monSel,
  input logic [1:0]            pumpUp,
  input logic [1:0]            pumpDn,
  input logic [1:0]            pumpEn,
  input logic                  lockMon,
  input logic [1:0]            finStb,
  input logic [1:0][CNT_W-1:0] errWidth,
  input logic [1:0]            secLock
);
  localparam logic [CNT_W-1:0] UNL_TH = CNT_W'(UNLOCK_CYC);
  localparam logic [CNT_W-1:0] LCK_TH = CNT_W'(LOCK_CYC);

  for (genvar i = 0; i < 2; i++) begin : g_a
    p_save_hiz_r7: assert property (@(posedge clk) disable iff (!rstN)
      (pwrSave[i] && $past(pwrSave[i])) |-> !pumpEn[i]);

    p_dz_one_r3: assert property (@(posedge clk) disable iff (!rstN)
      (pumpUp[i] && pumpDn[i]) |=> !(pumpUp[i] && pumpDn[i]));

    p_wide_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
      (finStb[i] && (errWidth[i] >= UNL_TH)) |=> !secLock[i]);

    p_lock_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(secLock[i]) |-> ($past(finStb[i]) && ($past(errWidth[i]) <= LCK_TH)));
  end

  p_all_save_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!monSel && (&pwrSave)) |-> lockMon);
endmodule

bind pfd_lock_top pfd_lock_chk #(
  .MAX_ERR(MAX_ERR), .UNLOCK_CYC(UNLOCK_CYC), .LOCK_CYC(LOCK_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .pwrSave(pwrSave), .monSel(monSel),
  .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpEn(pumpEn), .lockMon(lockMon),
  .finStb(finStb), .errWidth(errWidth), .secLock(secLock)
);

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_MAX = 63, P_UNL = 4, P_LCK = 2, P_RUN = 3, P_CAP = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] refIn = '0, fbIn = '0, polHigh = 2'b11, pwrSave = '0, monSrc = '0;
  logic monSel = 1'b0;
  logic [1:0] pumpUp, pumpDn, pumpEn;
  logic lockMon;

  int nChk = 0, nErr = 0, leadCycles = 0;
  bit running = 0, finished = 0;

  // behavioural reference state
  int mSt[2], mCnt[2], mRun[2];
  bit mLock[2], mDz[2], mWake[2], mRefQ[2], mFbQ[2];

  pfd_lock_top #(.MAX_ERR(P_MAX), .UNLOCK_CYC(P_UNL), .LOCK_CYC(P_LCK),
                 .LOCK_RUN(P_RUN), .WAKE_CAP(P_CAP)) u0 (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn), .polHigh(polHigh),
    .pwrSave(pwrSave), .monSel(monSel), .monSrc(monSrc),
    .pumpUp(pumpUp), .pumpDn(pumpDn), .pumpEn(pumpEn), .lockMon(lockMon)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nErr++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (!rstN) begin
        mSt[s] = 0; mCnt[s] = 0; mRun[s] = 0; mLock[s] = 0;
        mDz[s] = 0; mWake[s] = 0; mRefQ[s] = 0; mFbQ[s] = 0;
      end else begin
        bit rr, rf, fin;
        int w;
        rr = refIn[s] && !mRefQ[s];
        rf = fbIn[s] && !mFbQ[s];
        fin = 0; w = 0;
        if (pwrSave[s]) begin
          mSt[s] = 0; mCnt[s] = 0; mRun[s] = 0; mLock[s] = 0; mDz[s] = 0; mWake[s] = 1;
        end else begin
          if (mSt[s] == 0) begin
            if (rr && rf) begin fin = 1; w = 0; end
            else if (rr) begin mSt[s] = 1; mCnt[s] = 1; end
            else if (rf) begin mSt[s] = 2; mCnt[s] = 1; end
          end else begin
            bit closer, again;
            closer = (mSt[s] == 1) ? rf : rr;
            again  = (mSt[s] == 1) ? rr : rf;
            if (closer) begin
              fin = 1; w = mCnt[s];
              if (again) mCnt[s] = 1;
              else begin mSt[s] = 0; mCnt[s] = 0; end
            end else if (mCnt[s] < P_MAX) mCnt[s]++;
          end
          mDz[s] = fin;
          if (fin) begin
            if (w >= P_UNL) begin mLock[s] = 0; mRun[s] = 0; end
            else if (w <= P_LCK) begin
              if (mRun[s] < P_RUN) mRun[s]++;
              if (mRun[s] >= P_RUN) mLock[s] = 1;
            end else mRun[s] = 0;
            mWake[s] = 0;
          end
        end
        mRefQ[s] = refIn[s];
        mFbQ[s]  = fbIn[s];
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      bit expMon;
      for (int s = 0; s < 2; s++) begin
        bit lead, gate, hi, eu, ed;
        lead = (mSt[s] != 0);
        gate = lead && !(mWake[s] && mCnt[s] > P_CAP);
        hi   = ((mSt[s] == 1) == polHigh[s]);
        eu   = mDz[s] || (gate && hi);
        ed   = mDz[s] || (gate && !hi);
        check($sformatf("R1/R2/R3/R4/R10 sec%0d drive {up,dn,en}", s),
              {pumpUp[s], pumpDn[s], pumpEn[s]}, {eu, ed, eu || ed});
      end
      if (monSel) expMon = monSrc[1] ? fbIn[monSrc[0]] : refIn[monSrc[0]];
      else        expMon = (pwrSave[0] || mLock[0]) && (pwrSave[1] || mLock[1]);
      check("R5/R6/R7/R8/R9/R11 monitor", lockMon, expMon);
      if (pumpUp[0] && !pumpDn[0]) leadCycles++;
    end
  end

  // one comparison on section s; gap = cycles between the two rising edges
  task automatic cmpEvt(input int s, input bit refFirst, input int gap);
    @(negedge clk); #1;
    if (refFirst || gap == 0) refIn[s] = 1'b1;
    if (!refFirst || gap == 0) fbIn[s] = 1'b1;
    for (int k = 1; k <= gap; k++) begin
      @(negedge clk);
      if (k == 1 && gap >= 2 && !pwrSave[s]) begin
        bit expUp;
        expUp = refFirst ~^ polHigh[s];
        check("R1 lead drive up", pumpUp[s], expUp);
        check("R1 lead drive dn", pumpDn[s], !expUp);
      end
      #1;
      if (k == 1) begin
        if (refFirst) refIn[s] = 1'b0; else fbIn[s] = 1'b0;
      end
      if (k == gap) begin
        if (refFirst) fbIn[s] = 1'b1; else refIn[s] = 1'b1;
      end
    end
    @(negedge clk);
    if (!pwrSave[s]) check("R3 closing pulse up&dn", pumpUp[s] && pumpDn[s], 1);
    #1;
    refIn[s] = 1'b0; fbIn[s] = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 idle released", pumpEn[s], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nErr++; nChk++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    pwrSave = 2'b10;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    running = 1;
    @(negedge clk);
    check("R11 reset drive", pumpEn, 0);
    check("R11 reset lock", lockMon, 0);

    // lock qualification on section 0, section 1 parked
    cmpEvt(0, 1, 1); cmpEvt(0, 1, 1);
    check("R6 two narrow not locked", lockMon, 0);
    cmpEvt(0, 1, 1);
    check("R6 three narrow locked", lockMon, 1);
    cmpEvt(0, 0, 3);
    check("R6 mid width holds lock", lockMon, 1);
    cmpEvt(0, 1, 5);
    check("R5 wide error drops lock", lockMon, 0);
    cmpEvt(0, 1, 1); cmpEvt(0, 0, 0); cmpEvt(0, 1, 3);
    cmpEvt(0, 1, 1); cmpEvt(0, 0, 2);
    check("R6 mid width resets run", lockMon, 0);
    cmpEvt(0, 1, 1);
    check("R6 run complete after reset", lockMon, 1);

    @(negedge clk); #1 pwrSave = 2'b00;
    @(negedge clk);
    check("R8 unlocked section blocks", lockMon, 0);
    #1 pwrSave = 2'b11;
    @(negedge clk);
    check("R8 both parked reads locked", lockMon, 1);
    #1 refIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 parked drive released", pumpEn[0], 0);
    #1 refIn[0] = 1'b0; pwrSave = 2'b10;
    @(negedge clk);
    check("R7 lock cleared after release", lockMon, 0);

    // wake-up cap
    #1 leadCycles = 0;
    cmpEvt(0, 1, 8);
    check("R10 first drive capped", leadCycles, P_CAP);
    #1 leadCycles = 0;
    cmpEvt(0, 1, 8);
    check("R10 later drive full", leadCycles, 8);

    // polarity low on section 0
    #1 polHigh[0] = 1'b0;
    cmpEvt(0, 0, 3);
    cmpEvt(0, 1, 3);
    cmpEvt(0, 1, 0);

    // section 1 with a repeated leader edge and a saturating error
    @(negedge clk); #1 pwrSave = 2'b01;
    cmpEvt(1, 0, 2);
    cmpEvt(1, 1, 0);
    @(negedge clk); #1 refIn[1] = 1'b1;
    @(negedge clk); #1 refIn[1] = 1'b0;
    @(negedge clk); #1 refIn[1] = 1'b1;
    @(negedge clk); #1 fbIn[1] = 1'b1;
    repeat (2) @(negedge clk);
    #1 refIn[1] = 1'b0; fbIn[1] = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 repeated leader edge closes once", pumpEn[1], 0);
    cmpEvt(1, 1, 70);

    // monitor select
    @(negedge clk); #1 pwrSave = 2'b11; monSel = 1'b1;
    refIn = 2'b01; fbIn = 2'b10;
    for (int src = 0; src < 4; src++) begin
      bit expRaw;
      #1 monSrc = src[1:0];
      @(negedge clk);
      expRaw = (src == 0) ? refIn[0] : (src == 1) ? refIn[1] : (src == 2) ? fbIn[0] : fbIn[1];
      check("R9 monitor pick A", lockMon, expRaw);
    end
    #1 refIn = 2'b10; fbIn = 2'b01;
    for (int src = 0; src < 4; src++) begin
      bit expRaw;
      #1 monSrc = src[1:0];
      @(negedge clk);
      expRaw = (src == 0) ? refIn[0] : (src == 1) ? refIn[1] : (src == 2) ? fbIn[0] : fbIn[1];
      check("R9 monitor pick B", lockMon, expRaw);
    end
    #1 refIn = '0; fbIn = '0; monSel = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule